// File: doc/BRIEF.md
# Configurable Output Logic Cell for a Programmable Logic Array

This block is one output cell of a small programmable logic device. The product-term array is not part of it: the array's term results arrive on `pterm`. Configuration arrives as static inputs. Two global selection bits are shared by every cell of the device. Each cell also has its own polarity bit and its own I/O bit. The cell ORs the product terms and applies polarity. In one mode it stores the sum in a flip-flop. It then drives the pin value and the pin enable, and returns a feedback value to the array.

There are three operating modes. In simple mode the cell is a combinational output that is always enabled. Its feedback comes from the neighbouring pin. In complex mode the cell is a combinational output whose enable comes from one dedicated product term. In registered mode the cell is either a flip-flop output, or a combinational I/O cell like the complex-mode cell. In the flip-flop case the register is clocked by the shared clock and enabled by the shared active-low enable pin. A parameter gives the cell's position in the device: middle, outermost or innermost. That position changes the feedback route in two of the modes.

The configuration is sampled on every clock. A new setting takes effect at the next clock edge. A power-on reset and a synchronous preload give direct control of the stored bit for test.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_por` is high the stored bit is 0 and the cell acts in simple mode. So `out_en` is 1 and `out_val` follows the OR of all terms under the polarity bit.
- R2: The mode is decoded from `gcfg_a`/`gcfg_b` as follows: 0/1 is registered, 1/1 is complex, and 1/0 or 0/0 is simple. A change on these bits, or on `cell_io`, becomes visible only after the next rising clock edge.
- R3: `cell_pol`=1 drives the selected sum or stored bit unchanged onto `out_val`. `cell_pol`=0 drives its inverse. This holds in every mode.
- R4: In registered mode with `cell_io`=0, every clock edge stores the OR of all `N_TERMS` terms. `out_val` shows the stored bit and `out_en` equals the inverse of `oe_n_pin`.
- R5: In complex mode, and in registered mode with `cell_io`=1, `out_val` is built from the OR of terms 1 to N_TERMS-1. Term 0 drives `out_en` only.
- R6: In simple mode `out_val` is built from the OR of all terms, and `out_en` is always 1.
- R7: In registered mode with `cell_io`=0, `fb_val` is the inverse of the stored bit.
- R8: In complex mode, and in registered mode with `cell_io`=1, `fb_val` is `pin_in`. The one exception is an outermost cell in complex mode, which returns `ded_in`.
- R9: In simple mode `fb_val` is `nbr_in`. An innermost cell returns 0.
- R10: `preload_en` high at a clock edge loads `preload_val` into the stored bit. This overrides both the capture and the clear caused by a configuration change.
- R11: At an edge where the decoded mode or `cell_io` differs from the active setting, and preload is idle, the stored bit is cleared.
- R12: `rst_por` acts asynchronously. The outputs change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared device clock |
| rst_por | input | 1 | Power-on reset, active high, asynchronous |
| preload_en | input | 1 | Load the stored bit at the next edge |
| preload_val | input | 1 | Value to load |
| gcfg_a | input | 1 | Global mode selection bit A |
| gcfg_b | input | 1 | Global mode selection bit B |
| cell_pol | input | 1 | 1 = active-high output, 0 = active-low |
| cell_io | input | 1 | In registered mode: 1 = combinational I/O cell |
| pterm | input | N_TERMS | Product-term results from the array |
| oe_n_pin | input | 1 | Shared active-low output enable pin |
| pin_in | input | 1 | Level on this cell's own pin |
| nbr_in | input | 1 | Level on the adjacent pin |
| ded_in | input | 1 | Dedicated input pin reached through an outermost cell |
| out_val | output | 1 | Value driven to the pin |
| out_en | output | 1 | Pin driver enable |
| fb_val | output | 1 | Feedback to the array |

## Verification
Two operations can both target the stored bit at the same clock edge. One is the clear caused by a configuration change; the other is a preload. To provoke this, the bench switches the cell from complex into registered mode in the same cycle as a preload of 1 with all terms at 0. After that edge it expects `out_val`=1 and `fb_val`=0, which shows the preload won. A directed sequence then covers the opposite case: it re-enters registered mode without a preload and expects 0, even though the terms would capture a 1.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

   typedef enum logic [1:0] {
      MODE_SIMPLE  = 2'd0,
      MODE_COMPLEX = 2'd1,
      MODE_REG     = 2'd2
   } mc_mode_e;

   localparam int POS_MID   = 0;
   localparam int POS_OUTER = 1;
   localparam int POS_INNER = 2;

   // 0/1 registered, 1/1 complex, anything else simple
   function automatic mc_mode_e decode_mode(input logic sel_a, input logic sel_b);
      if (!sel_a && sel_b)      return MODE_REG;
      else if (sel_a && sel_b)  return MODE_COMPLEX;
      else                      return MODE_SIMPLE;
   endfunction

endpackage

// File: rtl/mc_cfg_track.sv
module mc_cfg_track
   import pld_mc_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     sel_a,
   input  logic     sel_b,
   input  logic     io_sel,
   output mc_mode_e mode_q,
   output logic     io_q,
   output logic     cfg_chg
);
   mc_mode_e mode_d;

   always_comb begin
      mode_d  = decode_mode(sel_a, sel_b);
      cfg_chg = (mode_d != mode_q) || (io_sel != io_q);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         mode_q <= MODE_SIMPLE;
         io_q   <= 1'b0;
      end else begin
         mode_q <= mode_d;
         io_q   <= io_sel;
      end
   end
endmodule

// File: rtl/mc_term_or.sv
module mc_term_or #(
   parameter int N_TERMS = 8
) (
   input  logic [N_TERMS-1:0] pterm,
   output logic               sum_all,
   output logic               sum_data,
   output logic               oe_term
);
   localparam int OE_IDX = 0;

   logic [N_TERMS-1:0] chain;

   assign chain[0] = 1'b0;

   generate
      for (genvar i = 1; i < N_TERMS; i++) begin : g_or
         assign chain[i] = chain[i-1] | pterm[i];
      end
   endgenerate

   assign sum_data = chain[N_TERMS-1];
   assign oe_term  = pterm[OE_IDX];
   assign sum_all  = sum_data | oe_term;
endmodule

// File: rtl/mc_state_bit.sv
module mc_state_bit (
   input  logic clk,
   input  logic rst,
   input  logic ld,
   input  logic ld_val,
   input  logic clr,
   input  logic cap,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)       q <= 1'b0;
      else if (ld)   q <= ld_val;
      else if (clr)  q <= 1'b0;
      else if (cap)  q <= d;
   end
endmodule

// File: rtl/mc_fb_route.sv
module mc_fb_route
   import pld_mc_pkg::*;
#(
   parameter int CELL_POS = POS_MID
) (
   input  mc_mode_e mode,
   input  logic     io_q,
   input  logic     st_q,
   input  logic     pin_in,
   input  logic     nbr_in,
   input  logic     ded_in,
   output logic     fb
);
   localparam bit IS_OUTER = (CELL_POS == POS_OUTER);
   localparam bit IS_INNER = (CELL_POS == POS_INNER);

   logic cplx_src;
   logic simp_src;

   assign cplx_src = IS_OUTER ? ded_in : pin_in;
   assign simp_src = IS_INNER ? 1'b0   : nbr_in;

   always_comb begin
      case (mode)
         MODE_REG:     fb = io_q ? pin_in : ~st_q;
         MODE_COMPLEX: fb = cplx_src;
         default:      fb = simp_src;
      endcase
   end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
   import pld_mc_pkg::*;
#(
   parameter int N_TERMS  = 8,
   parameter int CELL_POS = POS_MID
) (
   input  logic               clk,
   input  logic               rst_por,
   input  logic               preload_en,
   input  logic               preload_val,
   input  logic               gcfg_a,
   input  logic               gcfg_b,
   input  logic               cell_pol,
   input  logic               cell_io,
   input  logic [N_TERMS-1:0] pterm,
   input  logic               oe_n_pin,
   input  logic               pin_in,
   input  logic               nbr_in,
   input  logic               ded_in,
   output logic               out_val,
   output logic               out_en,
   output logic               fb_val
);
   generate
      if (N_TERMS < 2) begin : g_bad_terms
         $error("pld_macrocell: N_TERMS must be at least 2");
      end
      if (CELL_POS < POS_MID || CELL_POS > POS_INNER) begin : g_bad_pos
         $error("pld_macrocell: CELL_POS out of range");
      end
   endgenerate

   mc_mode_e mode_q;
   logic     io_q;
   logic     cfg_chg;
   logic     sum_all;
   logic     sum_data;
   logic     oe_term;
   logic     st_q;
   logic     reg_cell;
   logic     raw_val;

   mc_cfg_track u_cfg (
      .clk     (clk),
      .rst     (rst_por),
      .sel_a   (gcfg_a),
      .sel_b   (gcfg_b),
      .io_sel  (cell_io),
      .mode_q  (mode_q),
      .io_q    (io_q),
      .cfg_chg (cfg_chg)
   );

   mc_term_or #(.N_TERMS(N_TERMS)) u_or (
      .pterm    (pterm),
      .sum_all  (sum_all),
      .sum_data (sum_data),
      .oe_term  (oe_term)
   );

   assign reg_cell = (mode_q == MODE_REG) && !io_q;

   mc_state_bit u_st (
      .clk    (clk),
      .rst    (rst_por),
      .ld     (preload_en),
      .ld_val (preload_val),
      .clr    (cfg_chg),
      .cap    (reg_cell),
      .d      (sum_all),
      .q      (st_q)
   );

   always_comb begin
      case (mode_q)
         MODE_REG: begin
            raw_val = io_q ? sum_data : st_q;
            out_en  = io_q ? oe_term  : ~oe_n_pin;
         end
         MODE_COMPLEX: begin
            raw_val = sum_data;
            out_en  = oe_term;
         end
         default: begin
            raw_val = sum_all;
            out_en  = 1'b1;
         end
      endcase
   end

   assign out_val = cell_pol ? raw_val : ~raw_val;

   mc_fb_route #(.CELL_POS(CELL_POS)) u_fb (
      .mode   (mode_q),
      .io_q   (io_q),
      .st_q   (st_q),
      .pin_in (pin_in),
      .nbr_in (nbr_in),
      .ded_in (ded_in),
      .fb     (fb_val)
   );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk
   import pld_mc_pkg::*;
#(
   parameter int N_TERMS = 8
) (
   input logic               clk,
   input logic               rst_por,
   input logic               preload_en,
   input logic               preload_val,
   input logic               gcfg_a,
   input logic               gcfg_b,
   input logic               cell_io,
   input logic [N_TERMS-1:0] pterm,
   input logic               oe_n_pin,
   input logic               out_en,
   input logic               fb_val,
   input mc_mode_e           mode_q,
   input logic               io_q,
   input logic               st_q
);
   logic     chg_seen;
   logic     reg_act;

   assign chg_seen = (decode_mode(gcfg_a, gcfg_b) != mode_q) || (cell_io != io_q);
   assign reg_act  = (mode_q == MODE_REG) && !io_q;

   // R1, R12
   p_por_state_r1: assert property (@(posedge clk)
      rst_por |-> (st_q == 1'b0 && mode_q == MODE_SIMPLE && out_en));

   // R10
   p_preload_r10: assert property (@(posedge clk) disable iff (rst_por)
      preload_en |=> (st_q == $past(preload_val)));

   // R11
   p_cfg_clear_r11: assert property (@(posedge clk) disable iff (rst_por)
      (!preload_en && chg_seen) |=> (st_q == 1'b0));

   // R4
   p_capture_r4: assert property (@(posedge clk) disable iff (rst_por)
      (!preload_en && !chg_seen && reg_act) |=> (st_q == $past(|pterm)));

   // R5
   p_hold_r5: assert property (@(posedge clk) disable iff (rst_por)
      (!preload_en && !chg_seen && !reg_act) |=> $stable(st_q));

   // R6
   p_simple_en_r6: assert property (@(posedge clk) disable iff (rst_por)
      (mode_q == MODE_SIMPLE) |-> out_en);

   // R4
   p_reg_oe_r4: assert property (@(posedge clk) disable iff (rst_por)
      reg_act |-> (out_en == !oe_n_pin));

   // R7
   p_reg_fb_r7: assert property (@(posedge clk) disable iff (rst_por)
      reg_act |-> (fb_val == !st_q));
endmodule

bind pld_macrocell pld_macrocell_chk #(.N_TERMS(N_TERMS)) u_chk (
   .clk         (clk),
   .rst_por     (rst_por),
   .preload_en  (preload_en),
   .preload_val (preload_val),
   .gcfg_a      (gcfg_a),
   .gcfg_b      (gcfg_b),
   .cell_io     (cell_io),
   .pterm       (pterm),
   .oe_n_pin    (oe_n_pin),
   .out_en      (out_en),
   .fb_val      (fb_val),
   .mode_q      (mode_q),
   .io_q        (io_q),
   .st_q        (st_q)
);

// File: tb/test_pld_macrocell.sv
`timescale 1ns/1ps
module test_pld_macrocell;
   import pld_mc_pkg::*;

   localparam int NT = 8;
   localparam int NV = 12;

   // {a, b, io, pol, pterm[7:0], oe_n, pin, nbr, exp_val, exp_en, exp_fb}
   localparam logic [17:0] VEC [NV] = '{
      18'b1001_00000000_101_011,
      18'b1000_00000100_010_010,
      18'b1001_10000000_110_110,
      18'b0001_00000001_001_111,
      18'b1101_00000001_110_011,
      18'b1101_00000010_001_100,
      18'b1100_10000001_110_011,
      18'b0111_01000000_010_101,
      18'b0101_00000001_001_110,
      18'b0100_00000000_111_101,
      18'b0101_11111111_000_110,
      18'b0100_00100000_100_000
   };

   logic          clk = 1'b0;
   logic          rst_por = 1'b1;
   logic          preload_en = 1'b0;
   logic          preload_val = 1'b0;
   logic          gcfg_a = 1'b1;
   logic          gcfg_b = 1'b0;
   logic          cell_pol = 1'b1;
   logic          cell_io = 1'b0;
   logic [NT-1:0] pterm = '0;
   logic          oe_n_pin = 1'b1;
   logic          pin_in = 1'b0;
   logic          nbr_in = 1'b0;
   logic          ded_in = 1'b0;
   logic          out_val, out_en, fb_val;
   logic          o_val, o_en, o_fb;
   logic          n_val, n_en, n_fb;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pld_macrocell #(.N_TERMS(NT), .CELL_POS(POS_MID)) i_pld_macrocell (
      .clk(clk), .rst_por(rst_por), .preload_en(preload_en), .preload_val(preload_val),
      .gcfg_a(gcfg_a), .gcfg_b(gcfg_b), .cell_pol(cell_pol), .cell_io(cell_io),
      .pterm(pterm), .oe_n_pin(oe_n_pin), .pin_in(pin_in), .nbr_in(nbr_in),
      .ded_in(ded_in), .out_val(out_val), .out_en(out_en), .fb_val(fb_val));

   pld_macrocell #(.N_TERMS(NT), .CELL_POS(POS_OUTER)) i_outer (
      .clk(clk), .rst_por(rst_por), .preload_en(preload_en), .preload_val(preload_val),
      .gcfg_a(gcfg_a), .gcfg_b(gcfg_b), .cell_pol(cell_pol), .cell_io(cell_io),
      .pterm(pterm), .oe_n_pin(oe_n_pin), .pin_in(pin_in), .nbr_in(nbr_in),
      .ded_in(ded_in), .out_val(o_val), .out_en(o_en), .fb_val(o_fb));

   pld_macrocell #(.N_TERMS(NT), .CELL_POS(POS_INNER)) i_inner (
      .clk(clk), .rst_por(rst_por), .preload_en(preload_en), .preload_val(preload_val),
      .gcfg_a(gcfg_a), .gcfg_b(gcfg_b), .cell_pol(cell_pol), .cell_io(cell_io),
      .pterm(pterm), .oe_n_pin(oe_n_pin), .pin_in(pin_in), .nbr_in(nbr_in),
      .ded_in(ded_in), .out_val(n_val), .out_en(n_en), .fb_val(n_fb));

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_cfg(input logic a, input logic b, input logic io, input logic pol,
                          input logic [NT-1:0] t, input logic oen);
      gcfg_a = a; gcfg_b = b; cell_io = io; cell_pol = pol; pterm = t; oe_n_pin = oen;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick();
      tick();
      // R1: in reset the cell is a simple, enabled output; terms 0, pol 1
      chk("R1", "out_en in reset", out_en, 1'b1);
      chk("R1", "out_val in reset", out_val, 1'b0);
      rst_por = 1'b0;
      tick();

      for (int i = 0; i < NV; i++) begin
         logic [17:0] v;
         logic is_reg, is_cplx;
         string t_en, t_fb;
         v = VEC[i];
         set_cfg(v[17], v[16], v[15], v[14], v[13:6], v[5]);
         pin_in = v[4];
         nbr_in = v[3];
         tick();
         tick();
         is_reg  = !v[17] && v[16];
         is_cplx = v[17] && v[16];
         if (is_reg && !v[15]) begin t_en = "R4"; t_fb = "R7"; end
         else if (is_reg || is_cplx) begin t_en = "R5"; t_fb = "R8"; end
         else begin t_en = "R6"; t_fb = "R9"; end
         chk("R3", $sformatf("vec %0d out_val", i), out_val, v[2]);
         chk(t_en, $sformatf("vec %0d out_en", i), out_en, v[1]);
         chk(t_fb, $sformatf("vec %0d fb_val", i), fb_val, v[0]);
      end

      // R2: previous registered setting remains until the edge
      set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
      #1;
      chk("R2", "out_en before edge", out_en, 1'b0);
      tick();
      chk("R2", "out_en after edge", out_en, 1'b1);

      // R11: re-entering registered mode clears instead of capturing
      set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0);
      tick();
      tick();
      chk("R4", "stored 1 captured", out_val, 1'b1);
      set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0);
      tick();
      set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0);
      tick();
      chk("R11", "cleared on mode change", out_val, 1'b0);
      tick();
      chk("R4", "capture resumes", out_val, 1'b1);

      // R10: preload beats capture
      pterm = 8'h00;
      preload_en = 1'b1;
      preload_val = 1'b1;
      tick();
      preload_en = 1'b0;
      preload_val = 1'b0;
      chk("R10", "preload over capture", out_val, 1'b1);
      tick();
      chk("R4", "capture after preload", out_val, 1'b0);

      // R10 with R11 in the same edge: preload wins
      set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
      tick();
      set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
      preload_en = 1'b1;
      preload_val = 1'b1;
      tick();
      preload_en = 1'b0;
      preload_val = 1'b0;
      chk("R10", "preload over change clear, val", out_val, 1'b1);
      chk("R7", "preload over change clear, fb", fb_val, 1'b0);

      // R8: outermost cell in complex mode returns the dedicated pin
      set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
      pin_in = 1'b0;
      ded_in = 1'b1;
      nbr_in = 1'b0;
      tick();
      chk("R8", "outer fb", o_fb, 1'b1);
      chk("R8", "middle fb", fb_val, 1'b0);

      // R9: innermost cell in simple mode has no feedback
      set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      nbr_in = 1'b1;
      tick();
      chk("R9", "inner fb", n_fb, 1'b0);
      chk("R9", "middle fb", fb_val, 1'b1);

      // R12: reset acts without a clock edge
      set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b1);
      tick();
      tick();
      chk("R4", "registered, disabled by pin", out_en, 1'b0);
      #5;
      rst_por = 1'b1;
      #1;
      chk("R12", "async reset enables output", out_en, 1'b1);
      @(negedge clk);
      rst_por = 1'b0;
      pterm = 8'h00;
      oe_n_pin = 1'b0;
      tick();
      tick();
      chk("R1", "stored bit zero after reset", out_val, 1'b0);
      chk("R1", "fb after reset", fb_val, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule